// File: doc/BRIEF.md
# Radix-4 Belief-Propagation Processing Element for Polar Decoding

This block updates one node group of a polar-code belief-propagation factor graph in which two neighbouring radix-2 stages have been merged into a single radix-4 stage. It has four left nodes and four right nodes. Each left node brings in a right-going message and sends out a left-going message. Each right node brings in a left-going message and sends out a right-going message. For each transfer, a direction input selects which group of four messages is produced. All messages are 7-bit sign-magnitude log-likelihood ratios.

The merged update equations are evaluated in a single pass of logic, with no cascade of radix-2 updates. Because the two directions are mirror images of each other, a single datapath serves both. In the right-going direction the datapath simply sees the two input buses swapped. Inside the datapath, terms with identical operands are computed once and shared, so it holds 18 scaled min-sum operators and 13 saturating adders. The input and output are valid/ready streams. With `OUT_REG=1` (the default), a single output register holds each result. With `OUT_REG=0`, the element is purely combinational. Scheduling across the graph and message storage belong to the surrounding decoder.

Top module: `bpe4x4_pe`

## Requirements
- R1: An LLR is sign-magnitude: bit 6 is the sign (1 = negative) and bits 5:0 are the magnitude. A negative zero on an input is treated as zero, and no output slot ever carries the code 7'b1000000.
- R2: The operator g(x,y) returns magnitude m - floor(m/8), where m = min(|x|,|y|). Its sign is the XOR of the input signs, and the sign is positive whenever the result magnitude is zero.
- R3: Every addition saturates the signed sum to the range -63..+63.
- R4: When dir=0, the inputs are p = lft_in and q = rgt_in, where lft_in carries the right-going messages of left nodes a..d and rgt_in carries the left-going messages of right nodes e..h. Slot k sits at bits [7k+6:7k]. Define u = p3+q3, v = g(p1,p2)+g(q1,q2), w = g(p2,q2) and z = g(p1,q1). The four slots of res are then:
  - slot 0 = g(q0, (g(p1,q2)+g(q1,p2)) + g(u,v))
  - slot 1 = g(q1, u+w) + g(q0, g(p0, q2+g(p2,u)))
  - slot 2 = g(q2, u+z) + g(q0, g(p0, q1+g(p1,u)))
  - slot 3 = ((q3+w)+z) + g(q0, g(p0,v))
- R5: When dir=1, the same four expressions are evaluated with p = rgt_in and q = lft_in. The result is the right-going messages for nodes e..h, in res slots 0..3.
- R6: Chains of additions are evaluated left to right, as grouped in R4, and every partial sum saturates before the next addition.
- R7: With OUT_REG=1, a transfer accepted at a clock edge appears on res and res_dir after that same edge with out_valid=1. out_valid falls after an edge where the result is taken and no new transfer is accepted.
- R8: With OUT_REG=1, in_ready = !out_valid || out_ready. While out_valid=1 and out_ready=0, out_valid, res and res_dir hold their values.
- R9: After reset, out_valid is 0.
- R10: With OUT_REG=0, out_valid follows in_valid, in_ready follows out_ready, and res shows the R4/R5 result in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input transfer offered |
| in_ready | output | 1 | Element can accept an input transfer |
| dir | input | 1 | 0: produce left-going messages, 1: produce right-going messages |
| lft_in | input | 28 | Right-going messages of left nodes a..d, 4 slots of 7 bits |
| rgt_in | input | 28 | Left-going messages of right nodes e..h, 4 slots of 7 bits |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| res | output | 28 | Four updated messages, 4 slots of 7 bits |
| res_dir | output | 1 | Direction the result was computed for |

## Verification
A fault in the datapath, such as a mis-shared subterm, a wrong scale shift, a missing clamp or a swapped direction mux, shows up on res in the first cycle after the affected transfer is accepted. The bench compares every slot on every valid cycle against an integer model that knows nothing of the RTL structure. A fault in the output stage shows up in the same or the next cycle as a wrong in_ready, a lost or duplicated out_valid, or res changing during a stall. Random back-pressure exercises this on every clock. The all-maximum, all-negative-maximum and negative-zero patterns drive every adder into saturation and every g operator into its zero-sign rule.

// File: rtl/bpe_pkg.sv
`timescale 1ns/1ps
package bpe_pkg;
  localparam int BPE_LLR_W    = 7;
  localparam int BPE_SCALE_SH = 3;
  localparam int BPE_SLOTS    = 4;

  typedef enum logic {
    DIR_LEFT  = 1'b0,
    DIR_RIGHT = 1'b1
  } bpe_dir_e;
endpackage

// File: rtl/bpe_gmin.sv
`timescale 1ns/1ps
// Scaled min-sum operator on sign-magnitude LLRs.
module bpe_gmin #(
  parameter int W  = bpe_pkg::BPE_LLR_W,
  parameter int SH = bpe_pkg::BPE_SCALE_SH
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] z
);
  localparam int MW = W - 1;

  logic [MW-1:0] mx, my, mn, ms;

  always_comb begin
    mx = x[MW-1:0];
    my = y[MW-1:0];
    mn = (mx < my) ? mx : my;
    ms = mn - (mn >> SH);
    z  = {(x[W-1] ^ y[W-1]) & (|ms), ms};
  end

  always_comb begin
    if (!$isunknown({x, y})) begin
      AST_GMIN_SHRINK: assert (z[MW-1:0] <= mx && z[MW-1:0] <= my); // R2
    end
  end
endmodule

// File: rtl/bpe_sadd.sv
`timescale 1ns/1ps
// Saturating adder on sign-magnitude LLRs.
module bpe_sadd #(
  parameter int W = bpe_pkg::BPE_LLR_W
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] z
);
  localparam int MW = W - 1;
  localparam int SW = W + 2;
  localparam logic signed [SW-1:0] LIM_P = SW'((1 << MW) - 1);
  localparam logic signed [SW-1:0] LIM_N = -LIM_P;

  logic signed [SW-1:0] vx, vy, sm, cl;
  logic [MW-1:0] mag;
  logic neg;

  always_comb begin
    vx = x[W-1] ? -$signed({{(SW-MW){1'b0}}, x[MW-1:0]})
                :  $signed({{(SW-MW){1'b0}}, x[MW-1:0]});
    vy = y[W-1] ? -$signed({{(SW-MW){1'b0}}, y[MW-1:0]})
                :  $signed({{(SW-MW){1'b0}}, y[MW-1:0]});
    sm = vx + vy;
    if (sm > LIM_P)      cl = LIM_P;
    else if (sm < LIM_N) cl = LIM_N;
    else                 cl = sm;
    neg = (cl < 0);
    mag = MW'(neg ? -cl : cl);
    z   = {neg, mag};
  end
endmodule

// File: rtl/bpe_core.sv
`timescale 1ns/1ps
// Shared radix-4 update datapath: left-going form, mirrored by swapping buses.
module bpe_core #(
  parameter int W  = bpe_pkg::BPE_LLR_W,
  parameter int SH = bpe_pkg::BPE_SCALE_SH,
  parameter int NS = bpe_pkg::BPE_SLOTS
) (
  input  logic [NS*W-1:0] p_bus,
  input  logic [NS*W-1:0] q_bus,
  output logic [NS*W-1:0] o_bus
);
  logic [W-1:0] p [NS];
  logic [W-1:0] q [NS];
  logic [W-1:0] o [NS];

  for (genvar k = 0; k < NS; k++) begin : g_slot
    assign p[k] = p_bus[k*W +: W];
    assign q[k] = q_bus[k*W +: W];
    assign o_bus[k*W +: W] = o[k];
  end

  // shared leaves
  logic [W-1:0] t_p1q2, t_q1p2, t_p1p2, t_q1q2, t_w, t_z, t_u, t_v;
  bpe_gmin #(.W(W), .SH(SH)) u_g01 (.x(p[1]), .y(q[2]), .z(t_p1q2));
  bpe_gmin #(.W(W), .SH(SH)) u_g02 (.x(q[1]), .y(p[2]), .z(t_q1p2));
  bpe_gmin #(.W(W), .SH(SH)) u_g03 (.x(p[1]), .y(p[2]), .z(t_p1p2));
  bpe_gmin #(.W(W), .SH(SH)) u_g04 (.x(q[1]), .y(q[2]), .z(t_q1q2));
  bpe_gmin #(.W(W), .SH(SH)) u_g05 (.x(p[2]), .y(q[2]), .z(t_w));
  bpe_gmin #(.W(W), .SH(SH)) u_g06 (.x(p[1]), .y(q[1]), .z(t_z));
  bpe_sadd #(.W(W))          u_s01 (.x(p[3]), .y(q[3]), .z(t_u));
  bpe_sadd #(.W(W))          u_s02 (.x(t_p1p2), .y(t_q1q2), .z(t_v));

  // slot 0
  logic [W-1:0] a_cross, a_uv, a_sum;
  bpe_sadd #(.W(W))          u_s03 (.x(t_p1q2), .y(t_q1p2), .z(a_cross));
  bpe_gmin #(.W(W), .SH(SH)) u_g07 (.x(t_u), .y(t_v), .z(a_uv));
  bpe_sadd #(.W(W))          u_s04 (.x(a_cross), .y(a_uv), .z(a_sum));
  bpe_gmin #(.W(W), .SH(SH)) u_g08 (.x(q[0]), .y(a_sum), .z(o[0]));

  // slot 1
  logic [W-1:0] b_uw, b_near, b_gpu, b_mid, b_in, b_far;
  bpe_sadd #(.W(W))          u_s05 (.x(t_u), .y(t_w), .z(b_uw));
  bpe_gmin #(.W(W), .SH(SH)) u_g09 (.x(q[1]), .y(b_uw), .z(b_near));
  bpe_gmin #(.W(W), .SH(SH)) u_g10 (.x(p[2]), .y(t_u), .z(b_gpu));
  bpe_sadd #(.W(W))          u_s06 (.x(q[2]), .y(b_gpu), .z(b_mid));
  bpe_gmin #(.W(W), .SH(SH)) u_g11 (.x(p[0]), .y(b_mid), .z(b_in));
  bpe_gmin #(.W(W), .SH(SH)) u_g12 (.x(q[0]), .y(b_in), .z(b_far));
  bpe_sadd #(.W(W))          u_s07 (.x(b_near), .y(b_far), .z(o[1]));

  // slot 2
  logic [W-1:0] c_uz, c_near, c_gpu, c_mid, c_in, c_far;
  bpe_sadd #(.W(W))          u_s08 (.x(t_u), .y(t_z), .z(c_uz));
  bpe_gmin #(.W(W), .SH(SH)) u_g13 (.x(q[2]), .y(c_uz), .z(c_near));
  bpe_gmin #(.W(W), .SH(SH)) u_g14 (.x(p[1]), .y(t_u), .z(c_gpu));
  bpe_sadd #(.W(W))          u_s09 (.x(q[1]), .y(c_gpu), .z(c_mid));
  bpe_gmin #(.W(W), .SH(SH)) u_g15 (.x(p[0]), .y(c_mid), .z(c_in));
  bpe_gmin #(.W(W), .SH(SH)) u_g16 (.x(q[0]), .y(c_in), .z(c_far));
  bpe_sadd #(.W(W))          u_s10 (.x(c_near), .y(c_far), .z(o[2]));

  // slot 3
  logic [W-1:0] d_s1, d_s2, d_in, d_far;
  bpe_sadd #(.W(W))          u_s11 (.x(q[3]), .y(t_w), .z(d_s1));
  bpe_sadd #(.W(W))          u_s12 (.x(d_s1), .y(t_z), .z(d_s2));
  bpe_gmin #(.W(W), .SH(SH)) u_g17 (.x(p[0]), .y(t_v), .z(d_in));
  bpe_gmin #(.W(W), .SH(SH)) u_g18 (.x(q[0]), .y(d_in), .z(d_far));
  bpe_sadd #(.W(W))          u_s13 (.x(d_s2), .y(d_far), .z(o[3]));
endmodule

// File: rtl/bpe4x4_pe.sv
`timescale 1ns/1ps
module bpe4x4_pe #(
  parameter int LLR_W    = bpe_pkg::BPE_LLR_W,
  parameter int SCALE_SH = bpe_pkg::BPE_SCALE_SH,
  parameter bit OUT_REG  = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic                    dir,
  input  logic [4*LLR_W-1:0]      lft_in,
  input  logic [4*LLR_W-1:0]      rgt_in,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [4*LLR_W-1:0]      res,
  output logic                    res_dir
);
  import bpe_pkg::*;
  localparam int NS = BPE_SLOTS;
  localparam int BW = NS * LLR_W;

  logic [BW-1:0] p_bus, q_bus, c_bus;

  // mirrored direction: swap which side feeds the shared datapath
  always_comb begin
    if (bpe_dir_e'(dir) == DIR_RIGHT) begin
      p_bus = rgt_in;
      q_bus = lft_in;
    end else begin
      p_bus = lft_in;
      q_bus = rgt_in;
    end
  end

  bpe_core #(.W(LLR_W), .SH(SCALE_SH), .NS(NS)) u_core (
    .p_bus(p_bus),
    .q_bus(q_bus),
    .o_bus(c_bus)
  );

  if (OUT_REG) begin : g_reg
    logic          v_q;
    logic [BW-1:0] r_q;
    logic          d_q;

    assign in_ready  = !v_q || out_ready;
    assign out_valid = v_q;
    assign res       = r_q;
    assign res_dir   = d_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        r_q <= '0;
        d_q <= 1'b0;
      end else if (in_ready) begin
        v_q <= in_valid;
        if (in_valid) begin
          r_q <= c_bus;
          d_q <= dir;
        end
      end
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(res) && $stable(res_dir)); // R8
    AST_READY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready); // R8
    AST_ACCEPT_LAT: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid); // R7
    AST_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && !in_valid |=> !out_valid); // R7
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign res       = c_bus;
    assign res_dir   = dir;
  end

  for (genvar k = 0; k < NS; k++) begin : g_chk
    AST_NO_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> res[k*LLR_W +: LLR_W] != {1'b1, {(LLR_W-1){1'b0}}}); // R1
  end
endmodule

// File: tb/sim_bpe4x4_pe.sv
`timescale 1ns/1ps
module sim_bpe4x4_pe;
  localparam int PER   = 10;
  localparam int NCYC  = 4000;
  localparam int WDOG  = 200000;

  logic clk = 1'b0;
  always #(PER/2) clk = ~clk;

  logic rst_n, in_valid, dir, out_ready;
  logic [27:0] lft_in, rgt_in;
  logic in_ready0, out_valid0, res_dir0;
  logic [27:0] res0;
  logic in_ready1, out_valid1, res_dir1;
  logic [27:0] res1;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  bpe4x4_pe #(.OUT_REG(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready0),
    .dir(dir), .lft_in(lft_in), .rgt_in(rgt_in), .out_valid(out_valid0),
    .out_ready(out_ready), .res(res0), .res_dir(res_dir0));

  bpe4x4_pe #(.OUT_REG(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready1),
    .dir(dir), .lft_in(lft_in), .rgt_in(rgt_in), .out_valid(out_valid1),
    .out_ready(out_ready), .res(res1), .res_dir(res_dir1));

  function automatic int dec(logic [6:0] v);
    return v[6] ? -int'(v[5:0]) : int'(v[5:0]);
  endfunction

  function automatic logic [6:0] enc(int v);
    return (v < 0) ? {1'b1, 6'(-v)} : {1'b0, 6'(v)};
  endfunction

  function automatic int gm(int x, int y);
    int ax, ay, m;
    ax = (x < 0) ? -x : x;
    ay = (y < 0) ? -y : y;
    m  = (ax < ay) ? ax : ay;
    m  = m - m / 8;
    return ((x < 0) != (y < 0)) ? -m : m;
  endfunction

  function automatic int sa(int x, int y);
    int s;
    s = x + y;
    if (s > 63) s = 63;
    if (s < -63) s = -63;
    return s;
  endfunction

  function automatic logic [27:0] ref_pe(logic [27:0] pb, logic [27:0] qb);
    int p [4];
    int q [4];
    int u, v, w, z, o0, o1, o2, o3;
    for (int k = 0; k < 4; k++) begin
      p[k] = dec(pb[k*7 +: 7]);
      q[k] = dec(qb[k*7 +: 7]);
    end
    u  = sa(p[3], q[3]);
    v  = sa(gm(p[1], p[2]), gm(q[1], q[2]));
    w  = gm(p[2], q[2]);
    z  = gm(p[1], q[1]);
    o0 = gm(q[0], sa(sa(gm(p[1], q[2]), gm(q[1], p[2])), gm(u, v)));
    o1 = sa(gm(q[1], sa(u, w)), gm(q[0], gm(p[0], sa(q[2], gm(p[2], u)))));
    o2 = sa(gm(q[2], sa(u, z)), gm(q[0], gm(p[0], sa(q[1], gm(p[1], u)))));
    o3 = sa(sa(sa(q[3], w), z), gm(q[0], gm(p[0], v)));
    return {enc(o3), enc(o2), enc(o1), enc(o0)};
  endfunction

  function automatic logic [6:0] rnd_llr();
    if ($urandom % 4 == 0) return {1'($urandom), 6'd63};
    return 7'($urandom);
  endfunction

  task automatic chk(string tag, logic [27:0] act, logic [27:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    #(PER * WDOG);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    bit ev, edir, prev_stall;
    logic [27:0] er, want;
    ev = 1'b0; edir = 1'b0; er = '0; prev_stall = 1'b0;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; dir = 1'b0;
    lft_in = '0; rgt_in = '0;
    repeat (3) @(negedge clk);
    chk("R9 out_valid in reset", {27'd0, out_valid0}, 28'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 out_valid after reset", {27'd0, out_valid0}, 28'd0);
    for (int c = 0; c < NCYC; c++) begin
      @(negedge clk);
      if (c < 10) begin
        in_valid = 1'b1; out_ready = 1'b1; dir = c[0];
        case (c >> 1)
          0: begin lft_in = {4{7'h3f}}; rgt_in = {4{7'h3f}}; end        // R3 all +63
          1: begin lft_in = {4{7'h7f}}; rgt_in = {4{7'h7f}}; end        // R3 all -63
          2: begin lft_in = {4{7'h40}}; rgt_in = {4{7'h40}}; end        // R1 negative zero
          3: begin lft_in = {7'h40, 7'h05, 7'h7f, 7'h3f};
                   rgt_in = {7'h3f, 7'h48, 7'h40, 7'h09}; end            // R1 R2 mixed
          default: begin lft_in = {7'h07, 7'h47, 7'h08, 7'h48};
                   rgt_in = {7'h10, 7'h51, 7'h0f, 7'h21}; end            // R2 scale rounding
        endcase
      end else begin
        in_valid  = ($urandom % 4) != 0;
        out_ready = ($urandom % 3) != 0;
        dir       = 1'($urandom);
        for (int k = 0; k < 4; k++) begin
          lft_in[k*7 +: 7] = rnd_llr();
          rgt_in[k*7 +: 7] = rnd_llr();
        end
      end
      #(PER/2 - 1);
      // registered element
      chk("R7 out_valid", {27'd0, out_valid0}, {27'd0, ev});
      chk("R8 in_ready", {27'd0, in_ready0}, {27'd0, (!ev || out_ready)});
      if (ev) begin
        if (prev_stall) chk("R8 hold res", res0, er);
        else if (edir) chk("R5 R2 R3 R6 res", res0, er);
        else chk("R4 R2 R3 R6 res", res0, er);
        chk("R7 res_dir", {27'd0, res_dir0}, {27'd0, edir});
        for (int k = 0; k < 4; k++)
          if (res0[k*7 +: 7] == 7'h40) chk("R1 negative zero", {21'd0, res0[k*7 +: 7]}, 28'd0);
      end
      // combinational element
      chk("R10 out_valid", {27'd0, out_valid1}, {27'd0, in_valid});
      chk("R10 in_ready", {27'd0, in_ready1}, {27'd0, out_ready});
      want = dir ? ref_pe(rgt_in, lft_in) : ref_pe(lft_in, rgt_in);
      if (in_valid) begin
        chk("R10 res", res1, want);
        chk("R10 res_dir", {27'd0, res_dir1}, {27'd0, dir});
      end
      // model step at the coming edge
      prev_stall = ev && !out_ready;
      if (!ev || out_ready) begin
        ev = in_valid;
        if (in_valid) begin
          er = want;
          edir = dir;
        end
      end
    end
    done = 1'b1;
    summary();
    $finish;
  end
endmodule